// File: doc/BRIEF.md
# T1 Zero-String and Line Alarm Detector

This block watches the two receive rails of a T1 line, one bit per clock (the clock runs at the line bit rate of 1.544 MHz). It reports runs of zeros, loss of carrier, the all-ones alarm, bipolar violations and zero-substitution code words. Level flags report line conditions. Single-cycle strobes mark violations and code words so that error counters can be built beside the block.

A mark is any bit in which at least one rail is high. If both rails are high in the same bit, the input is plain NRZ (the rails are tied together). That bit counts as a one, but it takes no part in polarity tracking. A mode input selects whether the violations that belong to a zero-substitution code word are counted. Code words are reported in either mode.

Top module: `t1_line_alarm_det`

## Requirements
- R1: `zero8_o` goes high in the cycle after the eighth consecutive bit in which neither rail is high. It stays high while the zero run continues.
- R2: `zero16_o` goes high in the cycle after the sixteenth consecutive zero bit. It stays high while the run continues.
- R3: A mark clears `zero8_o` and `zero16_o` in the cycle after it is sampled.
- R4: `carrier_loss_o` goes high in the cycle after the 192nd consecutive zero bit.
- R5: While carrier loss is set, the bits are split into back-to-back 112-bit windows. The first window starts with the bit after the one that set the flag. At the end of a window that held 14 or more marks, the flag clears. Otherwise it stays high.
- R6: From reset, the bits are split into back-to-back windows of 4632 bits. At the end of each window, `ais_o` is set if the window held 5 or fewer zeros and cleared if it held 6 or more. It changes at no other time.
- R7: A single-rail mark whose polarity matches the previous single-rail mark is a violation. For a violation sampled at edge t, `bpv_o` is high for exactly the one cycle after edge t+4.
- R8: `b8zs_cw_o` pulses for one cycle after the last bit of a code word 000VB0VB, whether or not `b8zs_en_i` is set. Here P is the polarity of the pulse before the word, V has polarity P then -P, and B has polarity -P then P.
- R9: With `b8zs_en_i` high, the two violations inside a detected code word give no `bpv_o` pulse. With it low, they do.
- R10: A bit with both rails high counts as a mark. It never gives a violation and leaves the tracked polarity unchanged.
- R11: While `rst_ni` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one received bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_i | input | 1 | Positive-pulse rail |
| neg_i | input | 1 | Negative-pulse rail |
| b8zs_en_i | input | 1 | Suppress violations that belong to code words |
| zero8_o | output | 1 | Eight-zero run flag |
| zero16_o | output | 1 | Sixteen-zero run flag |
| carrier_loss_o | output | 1 | Carrier loss flag |
| ais_o | output | 1 | All-ones alarm flag |
| bpv_o | output | 1 | Violation strobe, delayed 4 bits |
| b8zs_cw_o | output | 1 | Code word strobe |

## Verification
A code word completes in the same cycle that the violation pipeline would release its first violation. So the code-word strobe and the decision to suppress that violation fall in one cycle. The bench provokes this with directed code words sent with the mode enabled and disabled, and with code words placed inside random bipolar traffic. In each case it compares `b8zs_cw_o` and `bpv_o` bit by bit against a reference model held in the bench. Carrier-loss window ends and all-ones window ends can also land on the same bit. Long runs through both checks judge the two flags independently.

// File: rtl/t1_det_pkg.sv
package t1_det_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_POS  = 2'b01,
    SYM_NEG  = 2'b10,
    SYM_BOTH = 2'b11
  } sym_t;

  function automatic sym_t sym_of(input logic p, input logic n);
    return sym_t'({n, p});
  endfunction

  function automatic sym_t sym_inv(input sym_t s);
    return sym_t'({s[0], s[1]});
  endfunction

  function automatic logic sym_single(input sym_t s);
    return s[0] ^ s[1];
  endfunction
endpackage

// File: rtl/t1_zero_mon.sv
module t1_zero_mon #(
  parameter int ZS_SHORT     = 8,
  parameter int ZS_LONG      = 16,
  parameter int CL_SET_ZEROS = 192,
  parameter int CL_WIN_BITS  = 112,
  parameter int CL_MIN_ONES  = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  output logic zs_short_o,
  output logic zs_long_o,
  output logic cl_o
);
  localparam int RW = $clog2(CL_SET_ZEROS + 1);
  localparam int WW = $clog2(CL_WIN_BITS);
  localparam int OW = $clog2(CL_WIN_BITS + 1);

  logic [RW-1:0] run_q, run_inc;
  logic [WW-1:0] win_q;
  logic [OW-1:0] ones_q, ones_nx;
  logic zs_short_q, zs_long_q, cl_q;

  // run length saturates at the carrier-loss threshold
  assign run_inc = (run_q == RW'(CL_SET_ZEROS)) ? run_q : run_q + 1'b1;
  assign ones_nx = ones_q + OW'(mark_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= '0;
      zs_short_q <= 1'b0;
      zs_long_q  <= 1'b0;
    end else if (mark_i) begin
      run_q      <= '0;
      zs_short_q <= 1'b0;
      zs_long_q  <= 1'b0;
    end else begin
      run_q <= run_inc;
      if (run_inc >= RW'(ZS_SHORT)) zs_short_q <= 1'b1;
      if (run_inc >= RW'(ZS_LONG))  zs_long_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_q   <= 1'b0;
      win_q  <= '0;
      ones_q <= '0;
    end else if (!cl_q) begin
      win_q  <= '0;
      ones_q <= '0;
      if (!mark_i && run_inc == RW'(CL_SET_ZEROS)) cl_q <= 1'b1;
    end else if (win_q == WW'(CL_WIN_BITS - 1)) begin
      win_q  <= '0;
      ones_q <= '0;
      if (ones_nx >= OW'(CL_MIN_ONES)) cl_q <= 1'b0;
    end else begin
      win_q  <= win_q + 1'b1;
      ones_q <= ones_nx;
    end
  end

  assign zs_short_o = zs_short_q;
  assign zs_long_o  = zs_long_q;
  assign cl_o       = cl_q;

  assert_long_implies_short_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zs_long_q |-> zs_short_q);
  assert_mark_clears_runs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_i |=> (!zs_short_q && !zs_long_q));
  assert_cl_needs_long_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cl_q) |-> zs_long_q);
endmodule

// File: rtl/t1_ais_det.sv
module t1_ais_det #(
  parameter int AIS_WIN_BITS  = 4632,
  parameter int AIS_MAX_ZEROS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  output logic ais_o
);
  localparam int WW = $clog2(AIS_WIN_BITS);
  localparam int ZW = $clog2(AIS_MAX_ZEROS + 2);

  logic [WW-1:0] win_q;
  logic [ZW-1:0] zc_q, zc_nx;
  logic win_last, ais_q;

  assign win_last = (win_q == WW'(AIS_WIN_BITS - 1));
  // count only up to one past the limit
  assign zc_nx = (!mark_i && zc_q != ZW'(AIS_MAX_ZEROS + 1)) ? zc_q + 1'b1 : zc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      zc_q  <= '0;
      ais_q <= 1'b0;
    end else if (win_last) begin
      win_q <= '0;
      zc_q  <= '0;
      ais_q <= (zc_nx <= ZW'(AIS_MAX_ZEROS));
    end else begin
      win_q <= win_q + 1'b1;
      zc_q  <= zc_nx;
    end
  end

  assign ais_o = ais_q;

  assert_ais_window_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_last |=> $stable(ais_q));
endmodule

// File: rtl/t1_bpv_mon.sv
module t1_bpv_mon
  import t1_det_pkg::*;
#(
  parameter int CW_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  input  logic b8zs_en_i,
  output logic bpv_o,
  output logic cw_o
);
  localparam int HD = CW_LEN - 1;    // stored history
  localparam int DD = CW_LEN / 2 + 1; // violation delay line
  localparam int V1 = CW_LEN / 2 - 1; // first violation tap at completion
  localparam int V2 = 0;              // second violation tap

  sym_t sym;
  sym_t hist_q [HD];
  logic [DD-1:0] cand_q, cand_nx;
  logic pol_vld_q, pol_pos_q, cand, cw, cw_q;

  assign sym  = sym_of(pos_i, neg_i);
  assign cand = sym_single(sym) && pol_vld_q && (pos_i == pol_pos_q);

  // hist_q[0] is the previous bit; the pattern is checked on its last bit
  always_comb begin
    cw = sym_single(hist_q[3]) && cand_q[V1];
    for (int i = 4; i < HD; i++) cw = cw && (hist_q[i] == SYM_ZERO);
    cw = cw && (hist_q[2] == sym_inv(hist_q[3])) && (hist_q[1] == SYM_ZERO) &&
         (hist_q[0] == sym_inv(hist_q[3])) && (sym == hist_q[3]);
  end

  always_comb begin
    cand_nx = {cand_q[DD-2:0], cand};
    if (cw && b8zs_en_i) begin
      cand_nx[V1+1] = 1'b0;
      cand_nx[V2+1] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HD; i++) hist_q[i] <= SYM_ZERO;
      cand_q    <= '0;
      pol_vld_q <= 1'b0;
      pol_pos_q <= 1'b0;
      cw_q      <= 1'b0;
    end else begin
      hist_q[0] <= sym;
      for (int i = 1; i < HD; i++) hist_q[i] <= hist_q[i-1];
      cand_q <= cand_nx;
      cw_q   <= cw;
      if (sym_single(sym)) begin
        pol_vld_q <= 1'b1;
        pol_pos_q <= pos_i;
      end
    end
  end

  assign bpv_o = cand_q[DD-1];
  assign cw_o  = cw_q;

  assert_nrz_no_violation_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_i && neg_i) |=> (!cand_q[0] && $stable(pol_pos_q)));
  assert_cw_strobe_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_q |=> !cw_q);
endmodule

// File: rtl/t1_line_alarm_det.sv
module t1_line_alarm_det #(
  parameter int ZS_SHORT      = 8,
  parameter int ZS_LONG       = 16,
  parameter int CL_SET_ZEROS  = 192,
  parameter int CL_WIN_BITS   = 112,
  parameter int CL_MIN_ONES   = 14,
  parameter int AIS_WIN_BITS  = 4632,
  parameter int AIS_MAX_ZEROS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  input  logic b8zs_en_i,
  output logic zero8_o,
  output logic zero16_o,
  output logic carrier_loss_o,
  output logic ais_o,
  output logic bpv_o,
  output logic b8zs_cw_o
);
  logic mark;
  assign mark = pos_i | neg_i;

  t1_zero_mon #(
    .ZS_SHORT(ZS_SHORT), .ZS_LONG(ZS_LONG), .CL_SET_ZEROS(CL_SET_ZEROS),
    .CL_WIN_BITS(CL_WIN_BITS), .CL_MIN_ONES(CL_MIN_ONES)
  ) u_zero (
    .clk_i(clk_i), .rst_ni(rst_ni), .mark_i(mark),
    .zs_short_o(zero8_o), .zs_long_o(zero16_o), .cl_o(carrier_loss_o)
  );

  t1_ais_det #(
    .AIS_WIN_BITS(AIS_WIN_BITS), .AIS_MAX_ZEROS(AIS_MAX_ZEROS)
  ) u_ais (
    .clk_i(clk_i), .rst_ni(rst_ni), .mark_i(mark), .ais_o(ais_o)
  );

  t1_bpv_mon #(.CW_LEN(8)) u_bpv (
    .clk_i(clk_i), .rst_ni(rst_ni), .pos_i(pos_i), .neg_i(neg_i),
    .b8zs_en_i(b8zs_en_i), .bpv_o(bpv_o), .cw_o(b8zs_cw_o)
  );

  assert_suppressed_cw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b8zs_cw_o && $past(b8zs_en_i)) |-> !bpv_o);
endmodule

// File: tb/sim_t1_line_alarm_det.sv
module sim_t1_line_alarm_det;
  logic clk = 1'b0, rst_ni = 1'b0, pos = 1'b0, neg = 1'b0, en = 1'b0;
  logic zero8, zero16, cl, ais, bpv, cw;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  t1_line_alarm_det u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pos_i(pos), .neg_i(neg), .b8zs_en_i(en),
    .zero8_o(zero8), .zero16_o(zero16), .carrier_loss_o(cl), .ais_o(ais),
    .bpv_o(bpv), .b8zs_cw_o(cw)
  );

  // reference model state
  int t = 0, zrun = 0, cwin = 0, cones = 0, bwin = 0, bz = 0;
  bit m_cl = 0, m_ais = 0, m_bpv = 0, m_cw = 0, pvld = 0, ppos = 0, bp = 0;
  logic [1:0] hs [16];
  bit ch [16];

  function automatic logic [1:0] inv2(input logic [1:0] s);
    return {s[0], s[1]};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bit %0d: actual %b expected %b", tag, t, act, exp);
    end
  endtask

  task automatic model_step(input logic p, input logic n);
    bit mk, single, c;
    logic [1:0] s [8];
    mk = p | n;
    single = p ^ n;
    if (mk) zrun = 0; else if (zrun < 192) zrun++;
    if (!m_cl) begin
      if (!mk && zrun == 192) begin m_cl = 1; cwin = 0; cones = 0; end
    end else begin
      cones += int'(mk);
      if (cwin == 111) begin
        if (cones >= 14) m_cl = 0;
        cwin = 0; cones = 0;
      end else cwin++;
    end
    bz += int'(!mk);
    if (bwin == 4631) begin m_ais = (bz <= 5); bwin = 0; bz = 0; end
    else bwin++;
    c = single && pvld && (p == ppos);
    if (single) begin pvld = 1; ppos = p; end
    hs[t % 16] = {n, p};
    ch[t % 16] = c;
    for (int k = 0; k < 8; k++) s[k] = hs[(t + 16 - k) % 16];
    m_cw = (t >= 7) && s[7] == 2'b00 && s[6] == 2'b00 && s[5] == 2'b00 &&
           (s[4] == 2'b01 || s[4] == 2'b10) && s[3] == inv2(s[4]) &&
           s[2] == 2'b00 && s[1] == inv2(s[4]) && s[0] == s[4] &&
           ch[(t + 12) % 16];
    if (m_cw && en) begin ch[(t + 12) % 16] = 0; ch[(t + 15) % 16] = 0; end
    m_bpv = (t >= 4) ? ch[(t + 12) % 16] : 1'b0;
  endtask

  task automatic send(input logic p, input logic n);
    bit both;
    pos = p; neg = n;
    both = p & n;
    @(posedge clk);
    model_step(p, n);
    #5;
    chk(p | n ? "R3 zero8" : "R1 zero8", zero8, logic'(zrun >= 8));
    chk(p | n ? "R3 zero16" : "R2 zero16", zero16, logic'(zrun >= 16));
    chk(m_cl ? "R4 carrier" : "R5 carrier", cl, m_cl);
    chk("R6 ais", ais, m_ais);
    chk(both ? "R10 bpv" : (en ? "R9 bpv" : "R7 bpv"), bpv, m_bpv);
    chk("R8 codeword", cw, m_cw);
    t++;
    @(negedge clk);
  endtask

  task automatic mark_alt();
    bp = ~bp;
    send(bp, ~bp);
  endtask

  task automatic zeros(input int k);
    for (int i = 0; i < k; i++) send(1'b0, 1'b0);
  endtask

  // 000VB0VB relative to the last pulse, which is bp
  task automatic codeword();
    logic P;
    P = bp;
    zeros(3);
    send(P, ~P); send(~P, P); send(1'b0, 1'b0); send(~P, P); send(P, ~P);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin hs[i] = 2'b00; ch[i] = 0; end
    void'($urandom(32'd7731));
    repeat (3) @(posedge clk);
    #3;
    chk("R11 zero8", zero8, 1'b0);
    chk("R11 zero16", zero16, 1'b0);
    chk("R11 carrier", cl, 1'b0);
    chk("R11 ais", ais, 1'b0);
    chk("R11 bpv", bpv, 1'b0);
    chk("R11 codeword", cw, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (20) mark_alt();
    zeros(7); mark_alt();                 // R1 boundary, 7 is not enough
    zeros(8); mark_alt();                 // R1 exact, R3 clear
    zeros(15); zeros(1); zeros(3); mark_alt(); // R2
    zeros(192);                           // R4 exact set
    chk("R4 directed", cl, 1'b1);
    for (int i = 0; i < 112; i++) if (i % 8 == 0 && i < 104) mark_alt(); else send(0, 0);
    chk("R5 13 ones keep", cl, 1'b1);
    for (int i = 0; i < 112; i++) if (i % 8 == 0) mark_alt(); else send(0, 0);
    chk("R5 14 ones clear", cl, 1'b0);
    repeat (4) mark_alt();
    en = 1'b0; codeword(); repeat (6) mark_alt();   // R8, violations counted
    en = 1'b1; codeword(); repeat (6) mark_alt();   // R9 suppression
    codeword(); codeword(); repeat (6) mark_alt();
    send(1, 1); send(1, 1); send(bp, ~bp); send(1, 1); repeat (6) mark_alt(); // R10
    send(bp, ~bp); repeat (5) mark_alt();          // plain violation R7
    for (int i = 0; i < 2 * 4632 + 50; i++) mark_alt();   // R6 set
    for (int i = 0; i < 3000; i++) begin              // random traffic
      int r;
      r = $urandom_range(0, 99);
      if (i % 500 == 0) en = ~en;
      if (r < 35) send(0, 0);
      else if (r < 40) send(1, 1);
      else if (r < 48) send(bp, ~bp);
      else if (r < 50) codeword();
      else mark_alt();
    end
    for (int i = 0; i < 4700; i++) begin              // sparse zeros, AIS boundary
      if ($urandom_range(0, 999) < 1) send(0, 0); else mark_alt();
    end
    zeros(200);
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 99) < 88) send(0, 0); else mark_alt();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule